// File: doc/BRIEF.md
# Speculation-Aware Integer Register Datapath

This block is a small integer datapath in which every general register carries a poison token beside its data word. A speculative load that meets a deferrable fault does not trap; it writes its destination with the token set. Arithmetic carries poison forward, so any result built from a poisoned source is itself poisoned. Compares that see poison write false to both of their predicate targets. A check operation looks at the token of one register and, when it is set, redirects control to a supplied recovery address.

One operation is presented per clock on a flat operand bus: a 3-bit opcode, destination and two source register indices, two predicate target indices, the load return word and its fault flag, and a recovery target. The two register read ports and one predicate read port are exposed as outputs, so the surrounding pipeline and the bench can observe state through the same paths an issuing operation uses. A non-speculative load that faults raises a trap output in the same cycle and leaves the register file alone. The redirect appears as a registered one-cycle pulse with its target.

Top module: `spec_token_datapath`

## Requirements
- R1: After reset every register reads data 0 with a clear token, every predicate above index 0 reads 0, and `redir_valid` is low.
- R2: Register 0 always reads data 0 with a clear token; any write to it has no effect.
- R3: A register write is seen on the read ports from the next cycle; a read of the destination in the same cycle returns the previous contents.
- R4: Opcodes 1 (add), 2 (subtract, a minus b) and 3 (xor) write the result of `src_a` and `src_b` to `dst`; the destination token is the OR of both source tokens, and data under a set token is not specified.
- R5: Opcode 5 (speculative load) with `ld_fault` low writes `ld_data` to `dst` with a clear token.
- R6: Opcode 5 with `ld_fault` high sets the destination token and never raises `trap`.
- R7: Opcode 4 (plain load) with `ld_fault` low writes `ld_data` with a clear token; with `ld_fault` high it raises `trap` combinationally in the same cycle and changes no register.
- R8: Opcode 6 (equality compare) writes (a==b) to predicate `ptgt_t` and its complement to `ptgt_f`; when either source token is set both targets receive 0.
- R9: Predicate 0 always reads 1 and writes to it are ignored; when both targets name the same entry, the `ptgt_t` value is the one kept.
- R10: Opcode 7 (check) with the `src_a` token set drives `redir_valid` high for the following cycle with `redir_target` equal to the `recov_target` it was issued with; otherwise no pulse follows.
- R11: With `op_valid` low, or opcode 0, no register, predicate, trap or redirect changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation code |
| dst | input | 7 | Destination register index |
| src_a | input | 7 | First source register index |
| src_b | input | 7 | Second source register index |
| ptgt_t | input | 6 | Predicate receiving the compare result |
| ptgt_f | input | 6 | Predicate receiving the complement |
| ld_data | input | 64 | Load return data |
| ld_fault | input | 1 | Load reports an exception |
| recov_target | input | 64 | Recovery address for a check |
| pq_idx | input | 6 | Predicate read index |
| pq_val | output | 1 | Predicate read value |
| rd_a_data | output | 64 | Data of register `src_a` |
| rd_a_tok | output | 1 | Token of register `src_a` |
| rd_b_data | output | 64 | Data of register `src_b` |
| rd_b_tok | output | 1 | Token of register `src_b` |
| trap | output | 1 | Plain load fault, same cycle |
| redir_valid | output | 1 | Registered redirect pulse |
| redir_target | output | 64 | Registered redirect address |

## Verification
The read of a register and a write to that same register fall in the same cycle whenever an operation names its destination as one of its sources, and a check can issue in the cycle its redirect from a previous check is still showing. Both are provoked by directed sequences and by a long random run confined to eight registers and eight predicates, so that write/read collisions, back-to-back checks and equal compare targets happen often. A behavioural reference model in the bench is compared every clock: read ports and trap before the edge against the pre-write model state, and the redirect just after the edge against the outcome of the check issued in the previous cycle.

// File: rtl/spt_pkg.sv
package spt_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_XOR   = 3'd3,
    OP_LD    = 3'd4,
    OP_LDS   = 3'd5,
    OP_CMPEQ = 3'd6,
    OP_CHK   = 3'd7
  } op_e;

  function automatic logic is_alu_op(op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_XOR);
  endfunction

  function automatic logic is_load_op(op_e op);
    return (op == OP_LD) || (op == OP_LDS);
  endfunction

endpackage

// File: rtl/spt_regfile.sv
module spt_regfile #(
  parameter int NREGS = 128,
  parameter int DW    = 64,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_idx,
  input  logic [AW-1:0] rb_idx,
  output logic [DW-1:0] ra_data,
  output logic          ra_tok,
  output logic [DW-1:0] rb_data,
  output logic          rb_tok,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          wt
);

  logic [DW-1:0] ent_data [NREGS];
  logic          ent_tok  [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign ent_data[g] = '0;
      assign ent_tok[g]  = 1'b0;
    end else begin : g_reg
      logic [DW-1:0] d_q;
      logic          t_q;
      logic          hit;
      assign hit = we && (wa == AW'(g));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          d_q <= '0;
          t_q <= 1'b0;
        end else if (hit) begin
          d_q <= wd;
          t_q <= wt;
        end
      end
      assign ent_data[g] = d_q;
      assign ent_tok[g]  = t_q;
    end
  end

  assign ra_data = ent_data[ra_idx];
  assign ra_tok  = ent_tok[ra_idx];
  assign rb_data = ent_data[rb_idx];
  assign rb_tok  = ent_tok[rb_idx];

endmodule

// File: rtl/spt_alu.sv
module spt_alu
  import spt_pkg::*;
#(
  parameter int DW = 64
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          ta,
  input  logic          tb,
  output logic [DW-1:0] res,
  output logic          res_tok,
  output logic          same
);

  function automatic logic [DW-1:0] calc(op_e o, logic [DW-1:0] x, logic [DW-1:0] y);
    case (o)
      OP_ADD:  return x + y;
      OP_SUB:  return x - y;
      OP_XOR:  return x ^ y;
      default: return '0;
    endcase
  endfunction

  function automatic logic merge_tok(logic x, logic y);
    return x | y;
  endfunction

  assign res     = calc(op, a, b);
  assign res_tok = merge_tok(ta, tb);
  assign same    = (a == b);

endmodule

// File: rtl/spt_predfile.sv
module spt_predfile #(
  parameter int NPRED = 64,
  localparam int PW   = $clog2(NPRED)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] idx_t,
  input  logic          val_t,
  input  logic [PW-1:0] idx_f,
  input  logic          val_f,
  input  logic [PW-1:0] rd_idx,
  output logic          rd_val
);

  logic [NPRED-1:0] ent;

  for (genvar g = 0; g < NPRED; g++) begin : g_p
    if (g == 0) begin : g_true
      assign ent[g] = 1'b1;
    end else begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= 1'b0;
        else if (we && (idx_t == PW'(g)))
          q <= val_t;
        else if (we && (idx_f == PW'(g)))
          q <= val_f;
      end
      assign ent[g] = q;
    end
  end

  assign rd_val = ent[rd_idx];

endmodule

// File: rtl/spt_chkunit.sv
module spt_chkunit #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [TW-1:0] target,
  output logic          rv,
  output logic [TW-1:0] rt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv <= 1'b0;
      rt <= '0;
    end else begin
      rv <= fire;
      if (fire) rt <= target;
    end
  end

endmodule

// File: rtl/spec_token_datapath.sv
module spec_token_datapath
  import spt_pkg::*;
#(
  parameter int NREGS = 128,
  parameter int NPRED = 64,
  parameter int DW    = 64,
  parameter int TW    = 64,
  localparam int RAW  = $clog2(NREGS),
  localparam int PAW  = $clog2(NPRED)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [2:0]     op_code,
  input  logic [RAW-1:0] dst,
  input  logic [RAW-1:0] src_a,
  input  logic [RAW-1:0] src_b,
  input  logic [PAW-1:0] ptgt_t,
  input  logic [PAW-1:0] ptgt_f,
  input  logic [DW-1:0]  ld_data,
  input  logic           ld_fault,
  input  logic [TW-1:0]  recov_target,
  input  logic [PAW-1:0] pq_idx,
  output logic           pq_val,
  output logic [DW-1:0]  rd_a_data,
  output logic           rd_a_tok,
  output logic [DW-1:0]  rd_b_data,
  output logic           rd_b_tok,
  output logic           trap,
  output logic           redir_valid,
  output logic [TW-1:0]  redir_target
);

  op_e op;
  assign op = op_e'(op_code);

  // decoded events, named for the checker
  logic          alu_sel;
  logic          ld_sel;
  logic          ld_trap;
  logic          cmp_sel;
  logic          chk_sel;
  logic          chk_fire;
  logic          wr_en;
  logic          wr_tok;
  logic [DW-1:0] wr_data;

  logic [DW-1:0] alu_res;
  logic          alu_tok;
  logic          alu_same;

  assign alu_sel = op_valid && is_alu_op(op);
  assign ld_sel  = op_valid && is_load_op(op);
  assign ld_trap = ld_sel && (op == OP_LD) && ld_fault;
  assign cmp_sel = op_valid && (op == OP_CMPEQ);
  assign chk_sel = op_valid && (op == OP_CHK);
  assign chk_fire = chk_sel && rd_a_tok;

  spt_alu #(.DW(DW)) u_alu (
    .op      (op),
    .a       (rd_a_data),
    .b       (rd_b_data),
    .ta      (rd_a_tok),
    .tb      (rd_b_tok),
    .res     (alu_res),
    .res_tok (alu_tok),
    .same    (alu_same)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_tok  = 1'b0;
    wr_data = '0;
    if (alu_sel) begin
      wr_en   = 1'b1;
      wr_tok  = alu_tok;
      wr_data = alu_res;
    end else if (ld_sel && !ld_trap) begin
      wr_en   = 1'b1;
      wr_tok  = (op == OP_LDS) && ld_fault;
      wr_data = ld_data;
    end
  end

  spt_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (src_a),
    .rb_idx  (src_b),
    .ra_data (rd_a_data),
    .ra_tok  (rd_a_tok),
    .rb_data (rd_b_data),
    .rb_tok  (rd_b_tok),
    .we      (wr_en),
    .wa      (dst),
    .wd      (wr_data),
    .wt      (wr_tok)
  );

  logic pv_t;
  logic pv_f;
  assign pv_t = !alu_tok && alu_same;
  assign pv_f = !alu_tok && !alu_same;

  spt_predfile #(.NPRED(NPRED)) u_pf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cmp_sel),
    .idx_t  (ptgt_t),
    .val_t  (pv_t),
    .idx_f  (ptgt_f),
    .val_f  (pv_f),
    .rd_idx (pq_idx),
    .rd_val (pq_val)
  );

  spt_chkunit #(.TW(TW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (chk_fire),
    .target (recov_target),
    .rv     (redir_valid),
    .rt     (redir_target)
  );

  assign trap = ld_trap;

endmodule

// File: rtl/spt_datapath_chk.sv
module spt_datapath_chk
  import spt_pkg::*;
#(
  parameter int RAW = 7,
  parameter int PAW = 6,
  parameter int DW  = 64,
  parameter int TW  = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic [2:0]     op_code,
  input logic [TW-1:0]  recov_target,
  input logic [PAW-1:0] pq_idx,
  input logic           pq_val,
  input logic [RAW-1:0] src_a,
  input logic [DW-1:0]  rd_a_data,
  input logic           rd_a_tok,
  input logic           rd_b_tok,
  input logic           trap,
  input logic           redir_valid,
  input logic [TW-1:0]  redir_target,
  input logic           wr_en,
  input logic           wr_tok,
  input logic           alu_sel
);

  AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == '0) |-> (rd_a_data == '0 && !rd_a_tok)); // R2

  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !wr_en); // R7

  AST_SPEC_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LDS) |-> !trap); // R6

  AST_TOKEN_PROPAGATE: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_sel && (rd_a_tok || rd_b_tok)) |-> wr_tok); // R4

  AST_CHECK_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CHK && rd_a_tok) |=>
      (redir_valid && redir_target == $past(recov_target))); // R10

  AST_NO_SPURIOUS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_code == OP_CHK && rd_a_tok) |=> !redir_valid); // R10

  AST_PRED_ZERO_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    (pq_idx == '0) |-> pq_val); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!wr_en && !trap)); // R11

endmodule

bind spec_token_datapath spt_datapath_chk #(
  .RAW(RAW), .PAW(PAW), .DW(DW), .TW(TW)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_code      (op_code),
  .recov_target (recov_target),
  .pq_idx       (pq_idx),
  .pq_val       (pq_val),
  .src_a        (src_a),
  .rd_a_data    (rd_a_data),
  .rd_a_tok     (rd_a_tok),
  .rd_b_tok     (rd_b_tok),
  .trap         (trap),
  .redir_valid  (redir_valid),
  .redir_target (redir_target),
  .wr_en        (wr_en),
  .wr_tok       (wr_tok),
  .alu_sel      (alu_sel)
);

// File: tb/spec_token_datapath_tb.sv
`timescale 1ns/1ps
module spec_token_datapath_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [6:0]  dst, src_a, src_b;
  logic [5:0]  ptgt_t, ptgt_f, pq_idx;
  logic [63:0] ld_data, recov_target;
  logic        ld_fault;
  logic        pq_val, rd_a_tok, rd_b_tok, trap, redir_valid;
  logic [63:0] rd_a_data, rd_b_data, redir_target;

  always #4 clk = ~clk;  // 125 MHz

  spec_token_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dst(dst), .src_a(src_a), .src_b(src_b), .ptgt_t(ptgt_t), .ptgt_f(ptgt_f),
    .ld_data(ld_data), .ld_fault(ld_fault), .recov_target(recov_target),
    .pq_idx(pq_idx), .pq_val(pq_val), .rd_a_data(rd_a_data), .rd_a_tok(rd_a_tok),
    .rd_b_data(rd_b_data), .rd_b_tok(rd_b_tok), .trap(trap),
    .redir_valid(redir_valid), .redir_target(redir_target)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [63:0] mref [128];
  bit          tref [128];
  bit          pref [64];
  bit          exp_rv;
  logic [63:0] exp_rt;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit pred_of(int i);
    return (i == 0) ? 1'b1 : pref[i];
  endfunction

  task automatic step(input bit v, input int op, input int d, input int a, input int b,
                      input int pt, input int pf, input logic [63:0] ldd, input bit flt,
                      input logic [63:0] tgt, input int pq, input string tag);
    logic [63:0] r;
    bit tk, eqv;
    @(negedge clk);
    op_valid = v; op_code = op[2:0]; dst = d[6:0]; src_a = a[6:0]; src_b = b[6:0];
    ptgt_t = pt[5:0]; ptgt_f = pf[5:0]; ld_data = ldd; ld_fault = flt;
    recov_target = tgt; pq_idx = pq[5:0];
    #1;
    // R3: reads reflect pre-write state
    check({tag, " R3 tok_a"}, {63'd0, rd_a_tok}, {63'd0, tref[a]});
    if (!tref[a]) check({tag, " R3 data_a"}, rd_a_data, mref[a]);
    check({tag, " R3 tok_b"}, {63'd0, rd_b_tok}, {63'd0, tref[b]});
    if (!tref[b]) check({tag, " R3 data_b"}, rd_b_data, mref[b]);
    check({tag, " R7 trap"}, {63'd0, trap}, {63'd0, (v && op == 4 && flt)});
    check({tag, " R8 pred"}, {63'd0, pq_val}, {63'd0, pred_of(pq)});
    // reference update
    exp_rv = 1'b0;
    if (v) begin
      case (op)
        1, 2, 3: begin
          r = (op == 1) ? mref[a] + mref[b] : (op == 2) ? mref[a] - mref[b] : mref[a] ^ mref[b];
          tk = tref[a] | tref[b];
          if (d != 0) begin mref[d] = r; tref[d] = tk; end
        end
        4: if (!flt && d != 0) begin mref[d] = ldd; tref[d] = 1'b0; end
        5: if (d != 0) begin mref[d] = ldd; tref[d] = flt; end
        6: begin
          tk  = tref[a] | tref[b];
          eqv = (mref[a] == mref[b]);
          if (pf != 0) pref[pf] = !tk && !eqv;
          if (pt != 0) pref[pt] = !tk && eqv;
        end
        7: begin exp_rv = tref[a]; exp_rt = tgt; end
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    check({tag, " R10 redir_valid"}, {63'd0, redir_valid}, {63'd0, exp_rv});
    if (exp_rv) check({tag, " R10 redir_target"}, redir_target, exp_rt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin mref[i] = '0; tref[i] = 1'b0; end
    for (int i = 0; i < 64; i++) pref[i] = 1'b0;
    exp_rv = 1'b0; exp_rt = '0;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; dst = '0; src_a = '0; src_b = '0;
    ptgt_t = '0; ptgt_f = '0; ld_data = '0; ld_fault = 1'b0; recov_target = '0; pq_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state of all registers and predicates
    check("R1 redir after reset", {63'd0, redir_valid}, 64'd0);
    for (int i = 0; i < 128; i++) step(1, 0, 0, i, 127 - i, 0, 0, '0, 0, '0, i % 64, "R1 scan");

    // R5 / R3: speculative load then same-cycle read of destination
    step(1, 5, 5, 0, 0, 0, 0, 64'h0000_1234_5678_9abc, 0, '0, 0, "R5 lds ok");
    step(1, 5, 6, 5, 5, 0, 0, 64'h0000_0000_0000_0011, 0, '0, 0, "R5 lds ok2");
    // R4: arithmetic on clean operands, destination also a source
    step(1, 1, 5, 5, 6, 0, 0, '0, 0, '0, 0, "R4 add");
    step(1, 2, 10, 5, 6, 0, 0, '0, 0, '0, 0, "R4 sub");
    step(1, 3, 11, 10, 5, 0, 0, '0, 0, '0, 0, "R4 xor");
    // R6: faulting speculative load sets token, no trap
    step(1, 5, 7, 5, 10, 0, 0, 64'hdead_beef, 1, '0, 0, "R6 lds fault");
    // R4: token propagation through either source
    step(1, 1, 8, 7, 5, 0, 0, '0, 0, '0, 0, "R4 prop a");
    step(1, 3, 9, 5, 8, 0, 0, '0, 0, '0, 0, "R4 prop b");
    // R8: compares, clean equal / unequal / tokened
    step(1, 6, 0, 5, 5, 3, 4, '0, 0, '0, 3, "R8 cmp eq");
    step(1, 6, 0, 5, 10, 12, 13, '0, 0, '0, 4, "R8 cmp ne");
    step(1, 6, 0, 7, 7, 3, 4, '0, 0, '0, 13, "R8 cmp tok");
    step(1, 0, 0, 0, 0, 0, 0, '0, 0, '0, 3, "R8 read t");
    step(1, 0, 0, 0, 0, 0, 0, '0, 0, '0, 4, "R8 read f");
    // R9: predicate 0 write ignored; same target, true value kept
    step(1, 6, 0, 5, 10, 0, 0, '0, 0, '0, 0, "R9 p0 write");
    step(1, 6, 0, 5, 5, 20, 20, '0, 0, '0, 0, "R9 same tgt");
    step(1, 0, 0, 0, 0, 0, 0, '0, 0, '0, 20, "R9 read same");
    // R7: plain load fault traps, no write; plain load clean writes
    step(1, 4, 5, 5, 0, 0, 0, 64'h5555, 1, '0, 0, "R7 ld fault");
    step(1, 4, 7, 7, 5, 0, 0, 64'h7777, 0, '0, 0, "R7 ld clear tok");
    step(1, 0, 0, 7, 5, 0, 0, '0, 0, '0, 0, "R7 readback");
    // R10: check tokened, check clean, back-to-back checks
    step(1, 7, 0, 8, 0, 0, 0, '0, 0, 64'h8000_0000_0000_0040, 0, "R10 chk tok");
    step(1, 7, 0, 5, 0, 0, 0, '0, 0, 64'h1111, 0, "R10 chk clean");
    step(1, 7, 0, 9, 0, 0, 0, '0, 0, 64'h2222, 0, "R10 chk b2b1");
    step(1, 7, 0, 8, 0, 0, 0, '0, 0, 64'h3333, 0, "R10 chk b2b2");
    // R2: write to register 0 ignored
    step(1, 5, 0, 0, 0, 0, 0, 64'hffff, 1, '0, 0, "R2 w0 lds");
    step(1, 1, 0, 5, 6, 0, 0, '0, 0, '0, 0, "R2 w0 add");
    step(1, 0, 0, 0, 0, 0, 0, '0, 0, '0, 0, "R2 read0");
    // R11: idle operations leave all state alone
    step(0, 5, 5, 5, 5, 3, 4, 64'h9999, 1, 64'h44, 3, "R11 idle lds");
    step(0, 7, 0, 8, 0, 0, 0, '0, 0, 64'h44, 0, "R11 idle chk");
    step(0, 4, 5, 5, 0, 0, 0, '0, 1, '0, 0, "R11 idle ld");
    step(1, 0, 5, 5, 8, 0, 0, 64'habc, 1, '0, 4, "R11 nop");

    // random mix over a small register window
    for (int n = 0; n < 3000; n++) begin
      int op_r, d_r, a_r, b_r;
      op_r = int'($urandom % 8);
      d_r  = int'($urandom % 8);
      a_r  = ($urandom % 16 == 0) ? int'($urandom % 128) : int'($urandom % 8);
      b_r  = int'($urandom % 8);
      step(($urandom % 10) != 0, op_r, d_r, a_r, b_r, int'($urandom % 8), int'($urandom % 8),
           {32'($urandom % 4), $urandom}, ($urandom % 3) == 0, {$urandom, $urandom},
           int'($urandom % 8), "RND");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule